// File: doc/BRIEF.md
# Priority-Resolving Content-Addressable Memory

This block is a parameterizable content-addressable memory. Each entry holds one data word plus a valid bit, and the stored word is the search key. No separate payload is kept. A search compares the presented word against every valid entry in parallel. The answer is the location of the entry that matched.

When several entries hold the searched word, a build-time priority rule picks one winner. The rule favours either the lowest or the highest matching address. The winner is reported one clock after the search, both as a one-hot vector and as a binary address. A write port fills an entry or clears it.

With the streaming mode enabled, the block also sends out every matching address, one per cycle, in priority order. The stream starts two cycles later than the single result, and a done pulse closes it. While a stream is in progress, the block refuses new searches.

Top module: `prio_cam`

## Requirements
- R1: After a synchronous reset, every entry is invalid, all result and stream outputs are zero, and `srch_ready` is high.
- R2: A write with `wr_clear` low stores `wr_data` at `wr_addr` and marks the entry valid. A later search for that word reports `res_hit`=1 and `res_addr`=that address in the cycle after the search is accepted, with `res_valid`=1.
- R3: A write with `wr_clear` high invalidates the entry, and an invalid entry never matches. A search with no match gives `res_valid`=1, `res_hit`=0, `res_addr`=0 and `res_onehot`=0.
- R4: With `LOW_FIRST`=1, the lowest matching address is reported when several entries match.
- R5: With `LOW_FIRST`=0, the highest matching address is reported when several entries match.
- R6: On a hit, `res_onehot` has exactly one bit set, at bit position `res_addr`.
- R7: A lower-priority match is reported only once every higher-priority matching entry has been cleared or overwritten with a different word.
- R8: A search in the same cycle as a write compares against the contents from before that write.
- R9: With `MULTI`=1, every matching address appears on `strm_addr` with `strm_valid`=1, one per cycle, in priority order. The first one appears two cycles after the single result. `strm_done` is high together with the last one.
- R10: With `MULTI`=1 and no match, `strm_done` pulses alone two cycles after the single result, and `strm_valid` stays low.
- R11: With `MULTI`=1, `srch_ready` is low from the cycle after an accepted search until the cycle that shows `strm_done`. A search presented while it is low is ignored and produces no `res_valid`.
- R12: A stream lists the matches present when its search was accepted. Writes made during the stream do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_clear | input | 1 | With wr_en: invalidate the entry instead of storing |
| wr_addr | input | AW | Entry written or cleared |
| wr_data | input | DATA_W | Word stored |
| srch_valid | input | 1 | Search request |
| srch_key | input | DATA_W | Word searched for |
| srch_ready | output | 1 | Block can take a search |
| res_valid | output | 1 | Single result present |
| res_hit | output | 1 | At least one entry matched |
| res_onehot | output | DEPTH | Winning entry, one-hot |
| res_addr | output | AW | Winning entry, binary |
| strm_valid | output | 1 | Streamed address present |
| strm_addr | output | AW | Streamed matching address |
| strm_done | output | 1 | Stream finished |

## Verification
The bench sweeps every key over several fills. These include repeated words, unique words with cleared gaps, and a fill where every entry holds the same word. Two instances with opposite priority rules run side by side. Wrong priority logic shows up as the wrong winner in the direction it mishandles. Broken invalidation makes cleared entries answer, and a missed zeroing leaves a stale address beside a miss. Other targeted runs cover a write in the same cycle as a search, which catches a design that reads the new word. They also cover searches held while the block is busy, which a broken handshake would accept, and clears issued during a stream, which catch a stream that is not taken from a snapshot. Streams are compared against the full list and order of matches. An off-by-one ends the stream early or late, and a dropped entry shortens the list.

// File: rtl/cam_pkg.sv
package cam_pkg;
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cam_prio_pick.sv
module cam_prio_pick #(
  parameter int DEPTH = 16,
  parameter bit LOW_FIRST = 1'b1,
  localparam int AW = cam_pkg::addr_bits(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic [DEPTH-1:0] sel_oh,
  output logic [AW-1:0]    sel_addr,
  output logic             sel_any
);
  // last assignment in the scan wins, so scan toward the favoured end
  always_comb begin
    sel_oh   = '0;
    sel_addr = '0;
    sel_any  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (LOW_FIRST) begin
        if (req[DEPTH-1-i]) begin
          sel_oh             = '0;
          sel_oh[DEPTH-1-i]  = 1'b1;
          sel_addr           = AW'(DEPTH-1-i);
          sel_any            = 1'b1;
        end
      end else begin
        if (req[i]) begin
          sel_oh    = '0;
          sel_oh[i] = 1'b1;
          sel_addr  = AW'(i);
          sel_any   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH = 16,
  localparam int AW = cam_pkg::addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_clear,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] key,
  output logic [DEPTH-1:0]  hit_vec
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [DEPTH-1:0]  vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_addr] <= ~wr_clear;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_clear) words[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (words[g] == key);
  end

  // R2: a store leaves the entry valid
  a_r2_store_valid: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_clear) |=> vld[$past(wr_addr)]);
  // R3: a cleared entry cannot match
  a_r3_clear_nomatch: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_clear) |=> !hit_vec[$past(wr_addr)]);
endmodule

// File: rtl/cam_stream.sv
module cam_stream #(
  parameter int DEPTH = 16,
  parameter bit LOW_FIRST = 1'b1,
  localparam int AW = cam_pkg::addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DEPTH-1:0] load_vec,
  output logic             busy,
  output logic             s_valid,
  output logic [AW-1:0]    s_addr,
  output logic             s_done
);
  logic [DEPTH-1:0] pend;
  logic             act;
  logic [DEPTH-1:0] p_oh;
  logic [AW-1:0]    p_addr;
  logic             p_any;
  logic [DEPTH-1:0] pend_rest;

  cam_prio_pick #(.DEPTH(DEPTH), .LOW_FIRST(LOW_FIRST)) u_pick (
    .req(pend), .sel_oh(p_oh), .sel_addr(p_addr), .sel_any(p_any));

  assign pend_rest = pend & ~p_oh;
  assign busy      = load | act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0; act <= 1'b0;
      s_valid <= 1'b0; s_addr <= '0; s_done <= 1'b0;
    end else begin
      s_valid <= 1'b0;
      s_addr  <= '0;
      s_done  <= 1'b0;
      if (load) begin
        pend <= load_vec;
        act  <= 1'b1;
      end else if (act) begin
        s_valid <= p_any;
        s_addr  <= p_addr;
        pend    <= pend_rest;
        if (pend_rest == '0) begin
          s_done <= 1'b1;
          act    <= 1'b0;
        end
      end
    end
  end

  // R9: nothing follows the closing pulse directly
  a_r9_gap_after_done: assert property (@(posedge clk) disable iff (rst)
    s_done |=> !s_valid);
  // R11: a new snapshot only arrives when idle
  a_r11_load_when_idle: assert property (@(posedge clk) disable iff (rst)
    load |-> !act);
endmodule

// File: rtl/prio_cam.sv
module prio_cam #(
  parameter int DATA_W = 16,
  parameter int DEPTH = 16,
  parameter bit LOW_FIRST = 1'b1,
  parameter bit MULTI = 1'b1,
  localparam int AW = cam_pkg::addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_clear,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              srch_valid,
  input  logic [DATA_W-1:0] srch_key,
  output logic              srch_ready,
  output logic              res_valid,
  output logic              res_hit,
  output logic [DEPTH-1:0]  res_onehot,
  output logic [AW-1:0]     res_addr,
  output logic              strm_valid,
  output logic [AW-1:0]     strm_addr,
  output logic              strm_done
);
  logic [DEPTH-1:0] hit_vec;
  logic [DEPTH-1:0] win_oh;
  logic [AW-1:0]    win_addr;
  logic             win_any;
  logic             accept;
  logic             go_q;
  logic [DEPTH-1:0] vec_q;
  logic             strm_busy;

  cam_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_clear(wr_clear),
    .wr_addr(wr_addr), .wr_data(wr_data), .key(srch_key), .hit_vec(hit_vec));

  cam_prio_pick #(.DEPTH(DEPTH), .LOW_FIRST(LOW_FIRST)) u_pick (
    .req(hit_vec), .sel_oh(win_oh), .sel_addr(win_addr), .sel_any(win_any));

  assign srch_ready = ~strm_busy;
  assign accept     = srch_valid & srch_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; res_hit <= 1'b0;
      res_onehot <= '0; res_addr <= '0;
      go_q <= 1'b0; vec_q <= '0;
    end else begin
      res_valid  <= accept;
      res_hit    <= accept & win_any;
      res_onehot <= accept ? win_oh : '0;
      res_addr   <= accept ? win_addr : '0;
      go_q       <= accept & MULTI;
      vec_q      <= accept ? hit_vec : '0;
    end
  end

  if (MULTI) begin : g_stream
    cam_stream #(.DEPTH(DEPTH), .LOW_FIRST(LOW_FIRST)) u_stream (
      .clk(clk), .rst(rst), .load(go_q), .load_vec(vec_q), .busy(strm_busy),
      .s_valid(strm_valid), .s_addr(strm_addr), .s_done(strm_done));
  end else begin : g_single
    assign strm_busy  = 1'b0;
    assign strm_valid = 1'b0;
    assign strm_addr  = '0;
    assign strm_done  = 1'b0;
  end

  // R6: at most one winner bit
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(res_onehot));
  // R6: the one-hot bit sits at the binary address
  a_r6_agree: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_onehot[res_addr]);
  // R3: a miss leaves the result fields at zero
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_addr == '0 && res_onehot == '0));
  // R11: a refused search yields no result
  a_r11_refused: assert property (@(posedge clk) disable iff (rst)
    !srch_ready |=> !res_valid);
endmodule

// File: tb/prio_cam_test.sv
module prio_cam_test;
  localparam int DW = 4;
  localparam int D  = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_clear = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic srch_valid = 1'b0;
  logic [DW-1:0] srch_key = '0;

  logic rdy_l, rv_l, hit_l, sv_l, sd_l;
  logic [D-1:0] oh_l;
  logic [AW-1:0] ad_l, sa_l;
  logic rdy_h, rv_h, hit_h, sv_h, sd_h;
  logic [D-1:0] oh_h;
  logic [AW-1:0] ad_h, sa_h;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] ref_mem [D];
  bit ref_vld [D];

  always #4 clk = ~clk;

  prio_cam #(.DATA_W(DW), .DEPTH(D), .LOW_FIRST(1'b1), .MULTI(1'b1)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_clear(wr_clear), .wr_addr(wr_addr),
    .wr_data(wr_data), .srch_valid(srch_valid), .srch_key(srch_key),
    .srch_ready(rdy_l), .res_valid(rv_l), .res_hit(hit_l), .res_onehot(oh_l),
    .res_addr(ad_l), .strm_valid(sv_l), .strm_addr(sa_l), .strm_done(sd_l));

  prio_cam #(.DATA_W(DW), .DEPTH(D), .LOW_FIRST(1'b0), .MULTI(1'b1)) uut_hi (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_clear(wr_clear), .wr_addr(wr_addr),
    .wr_data(wr_data), .srch_valid(srch_valid), .srch_key(srch_key),
    .srch_ready(rdy_h), .res_valid(rv_h), .res_hit(hit_h), .res_onehot(oh_h),
    .res_addr(ad_h), .strm_valid(sv_h), .strm_addr(sa_h), .strm_done(sd_h));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input bit clr);
    @(negedge clk);
    wr_en = 1'b1; wr_clear = clr; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0; wr_clear = 1'b0;
    ref_vld[a] = !clr;
    if (!clr) ref_mem[a] = DW'(d);
  endtask

  // mode 0 plain, 1 hold request while busy, 2 clear entries during stream
  task automatic search(input int key, input int mode, input string tg);
    int lo[D];
    int hi[D];
    int cnt = 0;
    int got_l = 0, got_h = 0;
    bit done = 0;
    for (int i = 0; i < D; i++)
      if (ref_vld[i] && ref_mem[i] == DW'(key)) begin lo[cnt] = i; cnt++; end
    for (int i = 0; i < cnt; i++) hi[i] = lo[cnt-1-i];
    @(negedge clk);
    chk({tg, " R11 ready idle"}, int'(rdy_l), 1);
    srch_valid = 1'b1; srch_key = DW'(key);
    @(negedge clk);
    chk({tg, " R2 valid lo"}, int'(rv_l), 1);
    chk({tg, " R2 valid hi"}, int'(rv_h), 1);
    chk({tg, " R3 hit lo"}, int'(hit_l), int'(cnt > 0));
    chk({tg, " R3 hit hi"}, int'(hit_h), int'(cnt > 0));
    chk({tg, " R4 addr lo"}, int'(ad_l), cnt > 0 ? lo[0] : 0);
    chk({tg, " R5 addr hi"}, int'(ad_h), cnt > 0 ? hi[0] : 0);
    chk({tg, " R6 onehot lo"}, int'(oh_l), cnt > 0 ? (1 << lo[0]) : 0);
    chk({tg, " R6 onehot hi"}, int'(oh_h), cnt > 0 ? (1 << hi[0]) : 0);
    chk({tg, " R11 busy"}, int'(rdy_l), 0);
    if (mode == 1) srch_key = DW'(key + 1);
    else srch_valid = 1'b0;
    @(negedge clk);
    if (mode == 1) chk({tg, " R11 refused"}, int'(rv_l), 0);
    srch_valid = 1'b0;
    chk({tg, " R9 no early stream"}, int'(sv_l), 0);
    for (int k = 0; k <= D && !done; k++) begin
      if (mode == 2 && k < D) begin
        wr_en = 1'b1; wr_clear = 1'b1; wr_addr = AW'(k);
        ref_vld[k] = 1'b0;
      end
      @(negedge clk);
      wr_en = 1'b0; wr_clear = 1'b0;
      if (sv_l) begin
        chk({tg, " R9 R12 stream lo"}, int'(sa_l), got_l < cnt ? lo[got_l] : -1);
        got_l++;
      end
      if (sv_h) begin
        chk({tg, " R9 R12 stream hi"}, int'(sa_h), got_h < cnt ? hi[got_h] : -1);
        got_h++;
      end
      chk({tg, " R9 done lockstep"}, int'(sd_h), int'(sd_l));
      if (sd_l) begin
        done = 1;
        chk({tg, cnt == 0 ? " R10 count" : " R9 count"}, got_l, cnt);
        chk({tg, " R9 count hi"}, got_h, cnt);
        chk({tg, " R11 ready at done"}, int'(rdy_l), 1);
      end
    end
    chk({tg, " R9 stream closed"}, int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin ref_vld[i] = 1'b0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", int'(rdy_l), 1);
    chk("R1 res_valid", int'(rv_l), 0);
    chk("R1 hit", int'(hit_l | hit_h), 0);
    chk("R1 stream", int'(sv_l | sd_l), 0);
    search(0, 0, "R1 empty");

    // fill with repeated words
    for (int i = 0; i < D; i++) wr(i, i % 3, 1'b0);
    for (int k = 0; k < 16; k++) search(k, 0, "sweepA");
    // unique words, even entries cleared
    for (int i = 0; i < D; i++) wr(i, i + 4, 1'b0);
    for (int i = 0; i < D; i += 2) wr(i, 0, 1'b1);
    for (int k = 0; k < 16; k++) search(k, 0, "sweepB R3");
    // every entry holds the same word
    for (int i = 0; i < D; i++) wr(i, 5, 1'b0);
    for (int k = 0; k < 16; k++) search(k, 0, "sweepC");

    // R7: lower-priority match waits for the higher ones
    for (int i = 0; i < D; i++) wr(i, 0, 1'b1);
    wr(2, 9, 1'b0); wr(4, 9, 1'b0); wr(6, 9, 1'b0);
    search(9, 0, "R7 three");
    wr(2, 0, 1'b1);
    search(9, 0, "R7 after clear");
    wr(4, 3, 1'b0);
    search(9, 0, "R7 after overwrite");
    search(3, 0, "R7 new word");

    // R8: same-cycle write sees old contents
    @(negedge clk);
    srch_valid = 1'b1; srch_key = 4'd9;
    wr_en = 1'b1; wr_clear = 1'b0; wr_addr = 3'd6; wr_data = 4'd1;
    @(negedge clk);
    srch_valid = 1'b0; wr_en = 1'b0;
    ref_mem[6] = 4'd1;
    chk("R8 old word hit", int'(hit_l), 1);
    chk("R8 old word addr", int'(ad_l), 6);
    repeat (4) @(negedge clk);
    search(9, 0, "R8 after write");
    search(1, 0, "R8 new word");

    // R11: held request while busy
    for (int i = 0; i < D; i++) wr(i, 7, 1'b0);
    search(7, 1, "R11 hold");
    // R12: clears during stream leave it unchanged
    search(7, 2, "R12 snapshot");
    search(7, 0, "R12 after clears");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule